// File: doc/BRIEF.md
# I2C Master Transaction Engine

This block is a byte-level controller for the host side of a two-wire serial bus. A host gives it one command at a time: open the bus, send a byte, receive a byte with a chosen acknowledge answer, re-open the bus without releasing it, or close the bus. The engine works out every bus phase for that command on its own. It drives the clock line and the data line only through open-drain pull-down enables, and it reads both lines back through a synchronizer. Reading the lines back lets a target slow the clock down by holding it low. It also lets the engine notice that another controller has won the data line, and step off the bus at that point.

The length of each clock phase is set at run time by two divider counts, given in system clock cycles. Results come back on a small set of status outputs: `busy` while a command is running, a one-cycle `done` when it ends, the last received byte, a not-acknowledged flag, and an arbitration-lost flag.

Command codes on `cmd_op_i`: 1 = open (START), 2 = send byte, 3 = receive byte, 4 = close (STOP), 5 = re-open (repeated START). Any other code does nothing. A command is taken only on a cycle where `cmd_valid_i` is high and `busy_o` is low.

Top module: `i2c_xact_engine`

## Requirements
- R1: While reset is asserted and right after it is released, both line enables are 0 (lines released) and busy, done, nack and arb_lost are 0.
- R2: An open command issued with the bus idle pulls SDA low while SCL is high (a START), then pulls SCL low and keeps it low. It ends with a one-cycle done pulse, and busy is low again afterwards.
- R3: A send-byte command puts the 8 bits of `cmd_wdata_i` on the bus MSB first. SDA changes only while SCL is low, and no START or STOP appears during the byte. On the 9th clock SDA is released and sampled: nack becomes 1 if it reads high and 0 if it reads low.
- R4: A receive-byte command samples 8 bits MSB first into `rdata_o`. On the 9th clock it pulls SDA low when `cmd_nack_i` = 0 and leaves SDA released when `cmd_nack_i` = 1.
- R5: A re-open command issued while the bus is held releases SDA with SCL low, releases SCL, then pulls SDA low while SCL is high. This makes a repeated START with no STOP in between, and the bus stays held.
- R6: A close command pulls SDA low with SCL low, releases SCL, then releases SDA while SCL is high (a STOP). Both lines are then released and the engine is idle.
- R7: After releasing SCL, the engine does not start timing the high phase until it reads SCL high. While a target holds SCL low, no bit completes and busy stays 1.
- R8: When the engine has released SDA to send a 1 and reads SDA low at the high-phase sample, it releases SCL and SDA on the same cycle. It sets arb_lost, pulses done and goes idle. arb_lost stays set until the next accepted open command clears it.
- R9: After an arbitration loss, open commands are ignored until a STOP (SDA rising while SCL is high) has been seen on the bus. After that, an open command is accepted.
- R10: While nack is 1, send-byte and receive-byte commands are ignored, and the bus stays held with SCL low. Re-open and close commands clear nack. Commands that do not fit the current state are ignored: send or receive while idle, open while held.
- R11: Outside a stretch, SCL low phases last `lo_cnt_i` cycles. SCL high phases last `hi_cnt_i` + SYNC_STAGES cycles, where the added cycles are the read-back latency of the synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid_i | input | 1 | Command strobe, taken when busy_o is low |
| cmd_op_i | input | 3 | Command code (1 open, 2 send, 3 receive, 4 close, 5 re-open) |
| cmd_wdata_i | input | 8 | Byte to send |
| cmd_nack_i | input | 1 | For receive: 1 leaves the acknowledge slot released |
| lo_cnt_i | input | DIV_W | SCL low phase length in clock cycles |
| hi_cnt_i | input | DIV_W | SCL high phase length in clock cycles after SCL reads high |
| scl_i | input | 1 | SCL line as read from the bus |
| sda_i | input | 1 | SDA line as read from the bus |
| scl_oe_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| busy_o | output | 1 | A command is running |
| done_o | output | 1 | One-cycle pulse when a command ends |
| rdata_o | output | 8 | Last received byte |
| nack_o | output | 1 | Last sent byte was not acknowledged |
| arb_lost_o | output | 1 | Arbitration was lost |

## Verification
The bench builds the engine with DIV_W = 6 and SYNC_STAGES = 2, and drives phase counts of 5 low and 3 high. With these values a whole byte takes under a hundred cycles, so complete open, transfer and close sequences fit easily in the run. They also make the expected phase lengths of 5 low and 5 high cycles short enough to measure exactly. A 200-cycle clock stretch is many times longer than any phase, which makes a missing stretch wait plain to see. The same small counts keep the window between an arbitration loss and the bus STOP short, so refused and accepted open commands can both be tried.

// File: rtl/i2c_eng_pkg.sv
package i2c_eng_pkg;

  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_START   = 3'd1,
    OP_WRITE   = 3'd2,
    OP_READ    = 3'd3,
    OP_STOP    = 3'd4,
    OP_RESTART = 3'd5
  } i2c_op_e;

  typedef enum logic [3:0] {
    S_IDLE,  // bus not owned, lines released
    S_STA,   // lines released, waiting for SCL high, setup time
    S_STB,   // SDA low with SCL high: start hold
    S_HOLD,  // bus owned, SCL low, waiting for a command
    S_BLO,   // bit low phase
    S_BHI,   // bit high phase
    S_RLO,   // repeated start: SCL low, SDA released
    S_PLO,   // stop: SCL low, SDA low
    S_PHI,   // stop: SCL high, SDA low
    S_PREL   // stop: SDA released, bus free time
  } eng_st_e;

endpackage

// File: rtl/i2c_rst_sync.sv
module i2c_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2,
  parameter int LINES  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] line_i,
  output logic [LINES-1:0] line_o
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] ff_q;
    // released lines idle high, so the chain resets to ones
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff_q <= '1;
      else         ff_q <= {ff_q[STAGES-2:0], line_i[g]};
    end
    assign line_o[g] = ff_q[STAGES-1];
  end
endmodule

// File: rtl/i2c_bus_watch.sv
module i2c_bus_watch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  input  logic arb_evt_i,
  output logic bus_free_o
);
  logic scl_prev_q, sda_prev_q, free_q;
  logic free_d, stop_seen;

  assign stop_seen = scl_s_i && scl_prev_q && sda_s_i && !sda_prev_q;

  always_comb begin
    free_d = free_q;
    if (arb_evt_i)      free_d = 1'b0;
    else if (stop_seen) free_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
      free_q     <= 1'b1;
    end else begin
      scl_prev_q <= scl_s_i;
      sda_prev_q <= sda_s_i;
      free_q     <= free_d;
    end
  end

  assign bus_free_o = free_q;

  // R9
  blocked_until_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!free_q && !stop_seen) |=> !free_q);
endmodule

// File: rtl/i2c_xact_engine.sv
module i2c_xact_engine
  import i2c_eng_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [2:0]       cmd_op_i,
  input  logic [7:0]       cmd_wdata_i,
  input  logic             cmd_nack_i,
  input  logic [DIV_W-1:0] lo_cnt_i,
  input  logic [DIV_W-1:0] hi_cnt_i,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             scl_oe_o,
  output logic             sda_oe_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [7:0]       rdata_o,
  output logic             nack_o,
  output logic             arb_lost_o
);
  localparam int              BIT_W    = 4;
  localparam logic [BIT_W-1:0] ACK_SLOT = BIT_W'(8);
  localparam logic [DIV_W-1:0] ONE      = DIV_W'(1);

  logic rst_n_i, scl_s, sda_s, bus_free, arb_evt;
  logic [1:0] lines_s;

  i2c_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk_i(clk_i), .rst_ni(rst_ni), .rst_no(rst_n_i));

  i2c_line_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_n_i), .line_i({scl_i, sda_i}), .line_o(lines_s));
  assign scl_s = lines_s[1];
  assign sda_s = lines_s[0];

  i2c_bus_watch u_watch (
    .clk_i(clk_i), .rst_ni(rst_n_i), .scl_s_i(scl_s), .sda_s_i(sda_s),
    .arb_evt_i(arb_evt), .bus_free_o(bus_free));

  eng_st_e          st_q, st_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic [7:0]       sh_q, sh_d, rdata_q, rdata_d;
  logic             rd_q, rd_d, mn_q, mn_d, samp_q, samp_d;
  logic             nack_q, nack_d, arb_q, arb_d;
  logic             scl_oe_q, scl_oe_d, sda_oe_q, sda_oe_d, done_q, done_d;

  logic [DIV_W-1:0] lo_lim, hi_lim;
  logic             lo_end, hi_end, sample_pt, samp_now, arb_hit, bit_drive, scl_fall;
  i2c_op_e          op;

  assign op        = i2c_op_e'(cmd_op_i);
  assign lo_lim    = (lo_cnt_i == '0) ? ONE : lo_cnt_i;
  assign hi_lim    = (hi_cnt_i == '0) ? ONE : hi_cnt_i;
  assign lo_end    = (cnt_q >= lo_lim - ONE);
  assign hi_end    = scl_s && (cnt_q >= hi_lim - ONE);
  assign sample_pt = (st_q == S_BHI) && scl_s && (cnt_q == '0);
  assign samp_now  = sample_pt ? sda_s : samp_q;
  assign arb_hit   = sample_pt && !rd_q && (bit_q < ACK_SLOT) && sh_q[7] && !sda_s;

  // next-state process
  always_comb begin
    st_d = st_q;  cnt_d = cnt_q;  bit_d = bit_q;  sh_d = sh_q;
    rd_d = rd_q;  mn_d = mn_q;    samp_d = samp_q;
    nack_d = nack_q;  arb_d = arb_q;  rdata_d = rdata_q;
    arb_evt = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (cmd_valid_i && op == OP_START && bus_free) begin
          st_d = S_STA;  cnt_d = '0;  arb_d = 1'b0;  nack_d = 1'b0;
        end
      end
      S_HOLD: begin
        if (cmd_valid_i) begin
          unique case (op)
            OP_RESTART: begin st_d = S_RLO; cnt_d = '0; nack_d = 1'b0; end
            OP_STOP:    begin st_d = S_PLO; cnt_d = '0; nack_d = 1'b0; end
            OP_WRITE: if (!nack_q) begin
              st_d = S_BLO;  cnt_d = '0;  bit_d = '0;  sh_d = cmd_wdata_i;  rd_d = 1'b0;
            end
            OP_READ: if (!nack_q) begin
              st_d = S_BLO;  cnt_d = '0;  bit_d = '0;  sh_d = 8'hFF;  rd_d = 1'b1;
              mn_d = cmd_nack_i;
            end
            default: ;
          endcase
        end
      end
      S_STA: begin
        if (hi_end)     begin st_d = S_STB; cnt_d = '0; end
        else if (scl_s) cnt_d = cnt_q + ONE;
      end
      S_STB: begin
        if (cnt_q >= hi_lim - ONE) begin st_d = S_HOLD; cnt_d = '0; end
        else                       cnt_d = cnt_q + ONE;
      end
      S_BLO: begin
        if (lo_end) begin st_d = S_BHI; cnt_d = '0; end
        else        cnt_d = cnt_q + ONE;
      end
      S_BHI: begin
        if (arb_hit) begin
          st_d = S_IDLE;  arb_d = 1'b1;  arb_evt = 1'b1;  cnt_d = '0;
        end else if (scl_s) begin
          if (sample_pt) samp_d = sda_s;
          if (hi_end) begin
            cnt_d = '0;
            if (bit_q == ACK_SLOT) begin
              st_d = S_HOLD;
              if (rd_q) rdata_d = sh_q;
              else      nack_d  = samp_now;
            end else begin
              sh_d  = {sh_q[6:0], samp_now};
              bit_d = bit_q + BIT_W'(1);
              st_d  = S_BLO;
            end
          end else begin
            cnt_d = cnt_q + ONE;
          end
        end
      end
      S_RLO: begin
        if (lo_end) begin st_d = S_STA; cnt_d = '0; end
        else        cnt_d = cnt_q + ONE;
      end
      S_PLO: begin
        if (lo_end) begin st_d = S_PHI; cnt_d = '0; end
        else        cnt_d = cnt_q + ONE;
      end
      S_PHI: begin
        if (hi_end)     begin st_d = S_PREL; cnt_d = '0; end
        else if (scl_s) cnt_d = cnt_q + ONE;
      end
      S_PREL: begin
        if (cnt_q >= hi_lim - ONE) begin st_d = S_IDLE; cnt_d = '0; end
        else                       cnt_d = cnt_q + ONE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  // line enables for the next state; SDA holds for one cycle when SCL falls
  always_comb begin
    unique case (st_d)
      S_HOLD, S_BLO, S_RLO, S_PLO: scl_oe_d = 1'b1;
      default:                     scl_oe_d = 1'b0;
    endcase
    scl_fall  = scl_oe_d && !scl_oe_q;
    bit_drive = (bit_d == ACK_SLOT) ? (rd_d && !mn_d) : !sh_d[7];
    unique case (st_d)
      S_STB, S_PHI: sda_oe_d = 1'b1;
      S_HOLD, S_BHI: sda_oe_d = sda_oe_q;
      S_BLO:        sda_oe_d = scl_fall ? sda_oe_q : bit_drive;
      S_RLO:        sda_oe_d = scl_fall ? sda_oe_q : 1'b0;
      S_PLO:        sda_oe_d = scl_fall ? sda_oe_q : 1'b1;
      default:      sda_oe_d = 1'b0;
    endcase
    done_d = (st_q != S_IDLE) && (st_q != S_HOLD) && ((st_d == S_IDLE) || (st_d == S_HOLD));
  end

  // register process
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      st_q <= S_IDLE;  cnt_q <= '0;  bit_q <= '0;  sh_q <= '0;
      rd_q <= 1'b0;    mn_q <= 1'b0; samp_q <= 1'b1;
      nack_q <= 1'b0;  arb_q <= 1'b0; rdata_q <= '0;
      scl_oe_q <= 1'b0; sda_oe_q <= 1'b0; done_q <= 1'b0;
    end else begin
      st_q <= st_d;  cnt_q <= cnt_d;  bit_q <= bit_d;  sh_q <= sh_d;
      rd_q <= rd_d;  mn_q <= mn_d;    samp_q <= samp_d;
      nack_q <= nack_d;  arb_q <= arb_d;  rdata_q <= rdata_d;
      scl_oe_q <= scl_oe_d;  sda_oe_q <= sda_oe_d;  done_q <= done_d;
    end
  end

  assign scl_oe_o   = scl_oe_q;
  assign sda_oe_o   = sda_oe_q;
  assign busy_o     = (st_q != S_IDLE) && (st_q != S_HOLD);
  assign done_o     = done_q;
  assign rdata_o    = rdata_q;
  assign nack_o     = nack_q;
  assign arb_lost_o = arb_q;

  // R8
  arb_release_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(arb_q) |-> (!scl_oe_q && !sda_oe_q && done_q));
  // R3
  sda_still_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (st_q == S_BHI && $past(st_q) == S_BHI) |-> $stable(sda_oe_q));
  // R7
  stretch_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (st_q == S_BHI && !scl_s) |=> (st_q == S_BHI));
  // R9
  refuse_start_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (st_q == S_IDLE && !bus_free && cmd_valid_i) |=> (st_q == S_IDLE));
  // R10
  nack_block_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (st_q == S_HOLD && nack_q && cmd_valid_i && (op == OP_WRITE || op == OP_READ))
      |=> (st_q == S_HOLD && scl_oe_q));
  // R2
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    done_q |=> !done_q);
endmodule

// File: tb/tb_i2c_xact_engine.sv
module tb_i2c_xact_engine;
  localparam int DW = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_nack = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [7:0] cmd_wdata = 8'h00;
  logic [DW-1:0] lo_cnt = DW'(5), hi_cnt = DW'(3);
  logic scl_oe, sda_oe, busy, done, nack, arb_lost;
  logic [7:0] rdata;

  logic stretch = 1'b0, other_low = 1'b0, tgt_rd = 1'b0, tgt_ack = 1'b0, tgt_low;
  logic [7:0] tgt_byte = 8'h00;
  wire scl_bus = ~scl_oe & ~stretch;
  wire sda_bus = ~sda_oe & ~tgt_low & ~other_low;

  int tests = 0, fails = 0, cyc = 0;
  int neg_cnt = 0, pos_cnt = 0, start_cnt = 0, stop_cnt = 0, base = 0;
  logic [7:0] mon_cap = 8'h00;
  logic mon_ack = 1'b1;

  always #4 clk = ~clk;

  i2c_xact_engine #(.DIV_W(DW), .SYNC_STAGES(2)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_wdata_i(cmd_wdata), .cmd_nack_i(cmd_nack), .lo_cnt_i(lo_cnt), .hi_cnt_i(hi_cnt),
    .scl_i(scl_bus), .sda_i(sda_bus), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .busy_o(busy),
    .done_o(done), .rdata_o(rdata), .nack_o(nack), .arb_lost_o(arb_lost));

  // bus monitor and simple target
  always @(negedge scl_bus) neg_cnt++;
  always @(posedge scl_bus) begin
    pos_cnt++;
    if (neg_cnt - base < 8)       mon_cap = {mon_cap[6:0], sda_bus};
    else if (neg_cnt - base == 8) mon_ack = sda_bus;
  end
  always @(negedge sda_bus) if (scl_bus) start_cnt++;
  always @(posedge sda_bus) if (scl_bus) stop_cnt++;

  always_comb begin
    int b;
    b = neg_cnt - base;
    tgt_low = 1'b0;
    if (tgt_rd && b >= 0 && b < 8) tgt_low = !tgt_byte[7-b];
    else if (!tgt_rd && b == 8)    tgt_low = tgt_ack;
  end

  typedef struct packed { logic rd; logic [7:0] dat; logic tack; logic mnack; } vec_t;
  localparam vec_t VECS [6] = '{
    '{1'b0, 8'hA5, 1'b1, 1'b0},
    '{1'b0, 8'h3C, 1'b0, 1'b0},
    '{1'b1, 8'h96, 1'b0, 1'b0},
    '{1'b1, 8'h5A, 1'b0, 1'b1},
    '{1'b0, 8'hFF, 1'b1, 1'b0},
    '{1'b1, 8'h00, 1'b0, 1'b1}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [7:0] wd, input logic nk);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_wdata = wd; cmd_nack = nk;
    base = neg_cnt;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0;
  endtask

  task automatic wait_done(input string tag);
    int n;
    n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    check(done == 1'b1, {tag, " done"}, 0, 1);
    @(negedge clk);
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d expected finish", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int s0, p0, h, l;
    // R1 reset state
    idle_cycles(3);
    check({scl_oe, sda_oe, busy, done, nack, arb_lost} == 6'b0, "R1 in reset", {scl_oe, sda_oe, busy}, 0);
    rst_n = 1'b1;
    idle_cycles(4);
    check({scl_oe, sda_oe, busy, done, nack, arb_lost} == 6'b0, "R1 after reset", {scl_oe, sda_oe, busy}, 0);

    // R10 send while idle is ignored
    issue(3'd2, 8'h00, 1'b0);
    idle_cycles(30);
    check(!busy && !scl_oe && !sda_oe, "R10 write in idle ignored", {busy, scl_oe}, 0);

    // table of transactions
    foreach (VECS[i]) begin
      s0 = start_cnt;
      issue(3'd1, 8'h00, 1'b0);
      wait_done("R2 start");
      check(start_cnt == s0 + 1 && scl_oe && !busy, "R2 start on bus", start_cnt - s0, 1);
      tgt_rd = VECS[i].rd; tgt_byte = VECS[i].dat; tgt_ack = VECS[i].tack;
      s0 = start_cnt; p0 = stop_cnt;
      issue(VECS[i].rd ? 3'd3 : 3'd2, VECS[i].dat, VECS[i].mnack);
      wait_done("R3/R4 byte");
      if (!VECS[i].rd) begin
        check(mon_cap == VECS[i].dat, "R3 bits on bus", mon_cap, VECS[i].dat);
        check(nack == !VECS[i].tack, "R3 nack flag", nack, !VECS[i].tack);
        check(start_cnt == s0 && stop_cnt == p0, "R3 no SDA edge in SCL high", start_cnt - s0 + stop_cnt - p0, 0);
      end else begin
        check(rdata == VECS[i].dat, "R4 read data", rdata, VECS[i].dat);
        check(mon_ack == VECS[i].mnack, "R4 ack slot", mon_ack, VECS[i].mnack);
      end
      tgt_rd = 1'b0; tgt_ack = 1'b0;
      p0 = stop_cnt;
      issue(3'd4, 8'h00, 1'b0);
      wait_done("R6 stop");
      check(stop_cnt == p0 + 1 && !scl_oe && !sda_oe && !busy && !nack, "R6 stop on bus", stop_cnt - p0, 1);
    end

    // R11 phase lengths: low 5, high 3 + 2
    issue(3'd1, 8'h00, 1'b0); wait_done("R11 start");
    tgt_ack = 1'b1;
    issue(3'd2, 8'h00, 1'b0);
    while (!scl_bus) @(negedge clk);
    h = 0; while (scl_bus)  begin h++; @(negedge clk); end
    l = 0; while (!scl_bus) begin l++; @(negedge clk); end
    check(h == 5, "R11 high phase", h, 5);
    check(l == 5, "R11 low phase", l, 5);
    wait_done("R11 byte");

    // R7 stretch: target holds SCL low
    stretch = 1'b1;
    p0 = pos_cnt;
    issue(3'd2, 8'h81, 1'b0);
    idle_cycles(200);
    check(busy && pos_cnt == p0, "R7 waits while stretched", pos_cnt - p0, 0);
    stretch = 1'b0;
    wait_done("R7 byte");
    check(mon_cap == 8'h81 && !nack, "R7 byte after stretch", mon_cap, 8'h81);

    // R5 repeated start then read
    s0 = start_cnt; p0 = stop_cnt;
    issue(3'd5, 8'h00, 1'b0); wait_done("R5 restart");
    check(start_cnt == s0 + 1 && stop_cnt == p0 && scl_oe, "R5 restart no stop", stop_cnt - p0, 0);
    tgt_ack = 1'b0; tgt_rd = 1'b1; tgt_byte = 8'hC3;
    issue(3'd3, 8'h00, 1'b1); wait_done("R5 read");
    check(rdata == 8'hC3, "R5 read after restart", rdata, 8'hC3);
    tgt_rd = 1'b0;

    // R10 nack blocks data commands; open while held ignored
    issue(3'd2, 8'h11, 1'b0); wait_done("R10 nacked write");
    check(nack == 1'b1, "R10 nack set", nack, 1);
    p0 = neg_cnt; s0 = start_cnt;
    issue(3'd2, 8'h00, 1'b0); idle_cycles(30);
    issue(3'd3, 8'h00, 1'b0); idle_cycles(30);
    issue(3'd1, 8'h00, 1'b0); idle_cycles(30);
    check(!busy && scl_oe && neg_cnt == p0 && start_cnt == s0, "R10 commands ignored", neg_cnt - p0, 0);
    issue(3'd4, 8'h00, 1'b0); wait_done("R10 stop");
    check(nack == 1'b0, "R10 stop clears nack", nack, 0);

    // R8 arbitration loss on a released bit
    issue(3'd1, 8'h00, 1'b0); wait_done("R8 start");
    other_low = 1'b1;
    issue(3'd2, 8'h80, 1'b0); wait_done("R8 lost");
    check(arb_lost && !scl_oe && !sda_oe && !busy, "R8 lines released", {arb_lost, scl_oe, sda_oe}, 3'b100);

    // R9 open refused until a STOP is seen
    issue(3'd1, 8'h00, 1'b0); idle_cycles(40);
    check(!busy && !scl_oe && !sda_oe && arb_lost, "R9 start refused", {busy, scl_oe}, 0);
    other_low = 1'b0;
    idle_cycles(10);
    s0 = start_cnt;
    issue(3'd1, 8'h00, 1'b0); wait_done("R9 start after stop");
    check(start_cnt == s0 + 1 && scl_oe, "R9 start accepted", start_cnt - s0, 1);
    check(arb_lost == 1'b0, "R8 flag cleared by start", arb_lost, 0);
    issue(3'd4, 8'h00, 1'b0); wait_done("R9 stop");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule